// File: doc/BRIEF.md
# Vector Byte Popcount Instruction Unit

This unit takes one 32-bit instruction word, decides whether it is the vector byte-popcount instruction in either of two instruction-set encodings, and executes it against an external 32-entry file of 64-bit registers. Each source register is split into byte lanes. The number of ones in each lane is written into the same lane of the destination register as an unsigned 8-bit value.

A caller presents the word on `insn_i` together with `isa_sel_i` and `en_i`, and pulses `start_i` while the unit is idle. The unit then walks a small sequence of read and write cycles, one pair for a single 64-bit register or two pairs for a 128-bit register pair. It raises `done_o` for one cycle at the end. If the word is not this instruction, the unit reports `not_mine_o` with `done_o`. If the word is this instruction but may not execute, it reports `undef_o` with `done_o`. In both of these cases the register file is not touched. A single enable input stands in for all the architectural enable and trap checks that would normally precede execution.

Top module: `vcnt_unit`

## Requirements
- R1: Each byte lane of a written result holds the number of ones in the same byte lane of the source register, so every lane value lies in 0..8. An all-zeros source gives 0x00 in every lane and an all-ones source gives 0x08 in every lane.
- R2: With `isa_sel_i`=0, the word is recognised only when bits 31:23 = 111100111. With `isa_sel_i`=1, it is recognised only when bits 31:23 = 111111111. In both cases bits 21:20 = 11, bits 17:16 = 00, bits 11:7 = 01010 and bit 4 = 0 are also required. Any other word raises `not_mine_o` (and never `undef_o`) together with `done_o` on the cycle after acceptance, and causes no register write.
- R3: The destination index is {bit 22, bits 15:12} and the source index is {bit 5, bits 3:0}. Bits 19:18 are the size field and bit 6 selects a register pair.
- R4: A recognised word whose size field is not 00 raises `undef_o` with `done_o` on the cycle after acceptance and causes no register write.
- R5: A recognised word with bit 6 = 1 and an odd destination index or an odd source index raises `undef_o` with no register write.
- R6: With bit 6 = 0, the unit reads register m and writes register d, and `done_o` rises three cycles after the accepting edge. With bit 6 = 1, it reads m and then m+1, writes d and then d+1, and `done_o` rises five cycles after the accepting edge. Two write cycles are never adjacent.
- R7: When `en_i` is low at acceptance, a recognised word raises `undef_o` with `done_o` on the next cycle and performs no register write.
- R8: `done_o` lasts exactly one cycle. `start_i` is ignored from acceptance until the cycle after `done_o`.
- R9: While `rst_ni` is low, `done_o`, `busy_o`, `rf_we_o`, `undef_o` and `not_mine_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Present an instruction; accepted when idle |
| insn_i | input | 32 | Instruction word |
| isa_sel_i | input | 1 | Encoding family: 0 first, 1 second |
| en_i | input | 1 | Execution permitted |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| undef_o | output | 1 | Recognised but undefined or disabled, valid with done_o |
| not_mine_o | output | 1 | Word is not this instruction, valid with done_o |
| rf_raddr_o | output | 5 | Register file read index |
| rf_rdata_i | input | 64 | Register file read data, same cycle |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 5 | Register file write index |
| rf_wdata_o | output | 64 | Register file write data |

## Verification
The assertions check several properties on every cycle. Every written lane stays within 0..8. Completion lasts one cycle and the status flags appear only with it. The two flags are never raised together. Write cycles are never adjacent, and the second write of a pair goes to the index one above the first. A disabled start completes on the next cycle without a write. Only the bench scenarios can show the rest: that lane counts match a reference popcount on random and corner-case operands, and that field extraction picks the right registers. They also show the exact latency of single and paired forms, that rejected words leave all 32 registers unchanged, and that a held start is not accepted twice.

// File: rtl/vcnt_pkg.sv
package vcnt_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned IDX_W  = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD0,
    ST_WR0,
    ST_RD1,
    ST_WR1,
    ST_DONE
  } vcnt_state_e;

  typedef struct packed {
    logic             mine;
    logic             undef;
    logic             pair;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] src;
  } vcnt_dec_t;
endpackage

// File: rtl/vcnt_decode.sv
module vcnt_decode
  import vcnt_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  input  logic              isa_sel_i,
  input  logic              en_i,
  output vcnt_dec_t         dec_o
);
  localparam logic [8:0] TOP_A = 9'b111100111;
  localparam logic [8:0] TOP_B = 9'b111111111;

  logic       top_ok, fix_ok;
  logic [1:0] size;
  logic       q, d_hi, m_hi;
  logic [3:0] vd, vm;

  assign size = insn_i[19:18];
  assign q    = insn_i[6];
  assign d_hi = insn_i[22];
  assign m_hi = insn_i[5];
  assign vd   = insn_i[15:12];
  assign vm   = insn_i[3:0];

  assign top_ok = (insn_i[31:23] == (isa_sel_i ? TOP_B : TOP_A));
  assign fix_ok = (insn_i[21:20] == 2'b11) && (insn_i[17:16] == 2'b00) &&
                  (insn_i[11:7] == 5'b01010) && !insn_i[4];

  always_comb begin
    dec_o.mine  = top_ok && fix_ok;
    dec_o.undef = !en_i || (size != 2'b00) || (q && (vd[0] || vm[0]));
    dec_o.pair  = q;
    dec_o.dst   = {d_hi, vd};
    dec_o.src   = {m_hi, vm};
  end
endmodule

// File: rtl/vcnt_popcnt.sv
module vcnt_popcnt #(
  parameter int unsigned ELEM_W = 8,
  parameter int unsigned ELEMS  = 8,
  localparam int unsigned REG_W = ELEM_W * ELEMS
) (
  input  logic [REG_W-1:0] src_i,
  output logic [REG_W-1:0] cnt_o
);
  for (genvar e = 0; e < ELEMS; e++) begin : g_lane
    logic [ELEM_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int b = 0; b < ELEM_W; b++)
        acc = acc + {{(ELEM_W-1){1'b0}}, src_i[e*ELEM_W+b]};
    end
    assign cnt_o[e*ELEM_W +: ELEM_W] = acc;
  end
endmodule

// File: rtl/vcnt_ctrl.sv
module vcnt_ctrl
  import vcnt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  vcnt_dec_t        dec_i,
  output vcnt_state_e      state_o,
  output logic [IDX_W-1:0] src_o,
  output logic [IDX_W-1:0] dst_o,
  output logic             undef_o,
  output logic             nm_o
);
  vcnt_state_e state_q, state_d;
  logic        pair_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = (!dec_i.mine || dec_i.undef) ? ST_DONE : ST_RD0;
      ST_RD0:  state_d = ST_WR0;
      ST_WR0:  state_d = pair_q ? ST_RD1 : ST_DONE;
      ST_RD1:  state_d = ST_WR1;
      ST_WR1:  state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pair_q  <= 1'b0;
      src_o   <= '0;
      dst_o   <= '0;
      undef_o <= 1'b0;
      nm_o    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        pair_q  <= dec_i.pair;
        src_o   <= dec_i.src;
        dst_o   <= dec_i.dst;
        nm_o    <= !dec_i.mine;
        undef_o <= dec_i.mine && dec_i.undef;
      end
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/vcnt_unit.sv
module vcnt_unit
  import vcnt_pkg::*;
#(
  parameter int unsigned ELEM_W = 8,
  parameter int unsigned ELEMS  = 8,
  localparam int unsigned REG_W = ELEM_W * ELEMS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic              isa_sel_i,
  input  logic              en_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              undef_o,
  output logic              not_mine_o,
  output logic [IDX_W-1:0]  rf_raddr_o,
  input  logic [REG_W-1:0]  rf_rdata_i,
  output logic              rf_we_o,
  output logic [IDX_W-1:0]  rf_waddr_o,
  output logic [REG_W-1:0]  rf_wdata_o
);
  localparam logic [IDX_W-1:0] IDX_ONE = 1;

  vcnt_dec_t        dec;
  vcnt_state_e      state;
  logic [IDX_W-1:0] src_q, dst_q;
  logic             undef_q, nm_q;
  logic [REG_W-1:0] cnt, cnt_q;

  vcnt_decode u_dec (
    .insn_i    (insn_i),
    .isa_sel_i (isa_sel_i),
    .en_i      (en_i),
    .dec_o     (dec)
  );

  vcnt_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .dec_i   (dec),
    .state_o (state),
    .src_o   (src_q),
    .dst_o   (dst_q),
    .undef_o (undef_q),
    .nm_o    (nm_q)
  );

  vcnt_popcnt #(.ELEM_W(ELEM_W), .ELEMS(ELEMS)) u_pop (
    .src_i (rf_rdata_i),
    .cnt_o (cnt)
  );

  // result register breaks the read-to-write path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 cnt_q <= '0;
    else if (state == ST_RD0 || state == ST_RD1) cnt_q <= cnt;
  end

  assign rf_raddr_o = (state == ST_RD1) ? src_q + IDX_ONE : src_q;
  assign rf_we_o    = (state == ST_WR0) || (state == ST_WR1);
  assign rf_waddr_o = (state == ST_WR1) ? dst_q + IDX_ONE : dst_q;
  assign rf_wdata_o = cnt_q;

  assign busy_o     = (state != ST_IDLE);
  assign done_o     = (state == ST_DONE);
  assign undef_o    = done_o && undef_q;
  assign not_mine_o = done_o && nm_q;
endmodule

// File: rtl/vcnt_unit_sva.sv
module vcnt_unit_sva #(
  parameter int unsigned ELEM_W = 8,
  parameter int unsigned ELEMS  = 8,
  localparam int unsigned REG_W = ELEM_W * ELEMS
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [31:0]      insn_i,
  input logic             isa_sel_i,
  input logic             en_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             undef_o,
  input logic             not_mine_o,
  input logic [4:0]       rf_raddr_o,
  input logic [REG_W-1:0] rf_rdata_i,
  input logic             rf_we_o,
  input logic [4:0]       rf_waddr_o,
  input logic [REG_W-1:0] rf_wdata_o
);
  localparam int unsigned EMAX = ELEM_W;

  for (genvar e = 0; e < ELEMS; e++) begin : g_rng
    assert_lane_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rf_we_o |-> (int'(rf_wdata_o[e*ELEM_W +: ELEM_W]) <= EMAX));
  end

  assert_flags_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(undef_o && not_mine_o));

  assert_flags_with_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (undef_o || not_mine_o) |-> (done_o && !rf_we_o));

  assert_write_spacing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |=> !rf_we_o);

  assert_pair_index_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && $past(rf_we_o, 2) && !$past(done_o)) |-> (rf_waddr_o == $past(rf_waddr_o, 2) + 5'd1));

  assert_disabled_reject_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !en_i) |=> (done_o && !rf_we_o && (undef_o || not_mine_o)));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R9: assert (!done_o && !busy_o && !rf_we_o && !undef_o && !not_mine_o);
    end
  end
endmodule

bind vcnt_unit vcnt_unit_sva #(.ELEM_W(ELEM_W), .ELEMS(ELEMS)) u_sva (.*);

// File: tb/vcnt_unit_tb_top.sv
`timescale 1ns/1ps
module vcnt_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] insn = '0;
  logic        sel = 1'b0;
  logic        en = 1'b1;
  logic        busy, done, undef, nm, we;
  logic [4:0]  raddr, waddr;
  logic [63:0] rdata, wdata;

  logic [63:0] rf [32];
  logic [63:0] exp_rf [32];
  int          wr_cnt = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  assign rdata = rf[raddr];
  always @(posedge clk) if (we) begin rf[waddr] <= wdata; wr_cnt <= wr_cnt + 1; end

  vcnt_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .insn_i(insn), .isa_sel_i(sel),
    .en_i(en), .busy_o(busy), .done_o(done), .undef_o(undef), .not_mine_o(nm),
    .rf_raddr_o(raddr), .rf_rdata_i(rdata), .rf_we_o(we), .rf_waddr_o(waddr),
    .rf_wdata_o(wdata)
  );

  function automatic logic [63:0] cnt64(input logic [63:0] v);
    logic [63:0] r = '0;
    for (int e = 0; e < 8; e++) begin
      int c = 0;
      for (int b = 0; b < 8; b++) c += int'(v[e*8+b]);
      r[e*8 +: 8] = 8'(c);
    end
    return r;
  endfunction

  function automatic logic [31:0] mk(input logic s, input logic d_hi, input logic [1:0] size,
                                     input logic [3:0] vd, input logic q, input logic m_hi,
                                     input logic [3:0] vm);
    logic [8:0] top = s ? 9'b111111111 : 9'b111100111;
    return {top, d_hi, 2'b11, size, 2'b00, vd, 5'b01010, q, m_hi, 1'b0, vm};
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] w, input logic s, input logic e, input int hold,
                     input logic [4:0] d, input logic [4:0] m, input logic q,
                     input logic x_und, input logic x_nm, input string tag);
    int lat = 0, wr0, bad = 0;
    bit rej = x_und || x_nm;
    int x_lat = rej ? 1 : (q ? 5 : 3);
    int x_wr = rej ? 0 : (q ? 2 : 1);
    for (int i = 0; i < 32; i++) exp_rf[i] = rf[i];
    if (!rej)
      for (int r = 0; r <= int'(q); r++) exp_rf[d + 5'(r)] = cnt64(exp_rf[m + 5'(r)]);
    @(negedge clk);
    wr0 = wr_cnt;
    insn = w; sel = s; en = e; start = 1'b1;
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      if (n >= hold) start = 1'b0;
      if (done && lat == 0) begin
        lat = n;
        check(tag, "undef flag", longint'(undef), longint'(x_und));
        check(tag, "not_mine flag", longint'(nm), longint'(x_nm));
      end
    end
    check(tag, "done latency", lat, x_lat);
    check(tag, "write count", wr_cnt - wr0, x_wr);
    for (int i = 0; i < 32; i++) if (rf[i] !== exp_rf[i]) begin
      bad++;
      $display("FAIL %s reg %0d: actual %h expected %h", tag, i, rf[i], exp_rf[i]);
    end
    n_chk++;
    if (bad != 0) n_bad++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1C0FFEE));
    for (int i = 0; i < 32; i++) rf[i] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "outputs in reset", {busy, done, we, undef, nm}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "idle after reset", {busy, done, we}, 0);

    // R1 corner operands
    rf[3] = '0;   run(mk(0, 0, 2'b00, 4'd5, 0, 0, 4'd3), 0, 1, 1, 5, 3, 0, 0, 0, "R1");
    check("R1", "zeros lanes", rf[5], 64'h0);
    rf[4] = '1;   run(mk(0, 0, 2'b00, 4'd6, 0, 0, 4'd4), 0, 1, 1, 6, 4, 0, 0, 0, "R1");
    check("R1", "ones lanes", rf[6], 64'h0808080808080808);
    // R6 pair, second encoding; R3 high index bits
    rf[18] = '1; rf[19] = 64'h0102040810204080;
    run(mk(1, 1, 2'b00, 4'd10, 1, 1, 4'd2), 1, 1, 1, 26, 18, 1, 0, 0, "R6");
    check("R3", "pair hi lanes", rf[27], 64'h0101010101010101);
    run(mk(1, 1, 2'b00, 4'd15, 0, 1, 4'd1), 1, 1, 1, 31, 17, 0, 0, 0, "R3");
    // in-place pair
    run(mk(0, 0, 2'b00, 4'd8, 1, 0, 4'd8), 0, 1, 1, 8, 8, 1, 0, 0, "R6");
    // R4 size
    run(mk(0, 0, 2'b01, 4'd2, 0, 0, 4'd1), 0, 1, 1, 2, 1, 0, 1, 0, "R4");
    run(mk(1, 0, 2'b11, 4'd2, 0, 0, 4'd1), 1, 1, 1, 2, 1, 0, 1, 0, "R4");
    // R5 odd indices with pair
    run(mk(0, 0, 2'b00, 4'd3, 1, 0, 4'd4), 0, 1, 1, 3, 4, 1, 1, 0, "R5");
    run(mk(0, 0, 2'b00, 4'd4, 1, 0, 4'd5), 0, 1, 1, 4, 5, 1, 1, 0, "R5");
    // R7 disabled
    run(mk(0, 0, 2'b00, 4'd2, 0, 0, 4'd1), 0, 0, 1, 2, 1, 0, 1, 0, "R7");
    // R2 not mine
    run(mk(0, 0, 2'b00, 4'd2, 0, 0, 4'd1), 1, 1, 1, 2, 1, 0, 0, 1, "R2");
    run(mk(1, 0, 2'b00, 4'd2, 0, 0, 4'd1), 0, 1, 1, 2, 1, 0, 0, 1, "R2");
    run(mk(0, 0, 2'b00, 4'd2, 0, 0, 4'd1) | 32'h10, 0, 1, 1, 2, 1, 0, 0, 1, "R2");
    run(mk(0, 0, 2'b01, 4'd2, 0, 0, 4'd1) | 32'h10000, 0, 0, 1, 2, 1, 0, 0, 1, "R2");
    // R8 held start accepted once
    run(mk(0, 0, 2'b00, 4'd9, 0, 0, 4'd11), 0, 1, 3, 9, 11, 0, 0, 0, "R8");

    // random mix
    for (int k = 0; k < 80; k++) begin
      logic s = 1'($urandom);
      logic dh = 1'($urandom), mh = 1'($urandom), q = 1'($urandom);
      logic [3:0] vd = 4'($urandom), vm = 4'($urandom);
      logic [1:0] sz = ($urandom % 6 == 0) ? 2'(1 + $urandom % 3) : 2'b00;
      logic e = ($urandom % 10 != 0);
      logic cor = ($urandom % 8 == 0);
      logic [31:0] w = mk(s, dh, sz, vd, q, mh, vm);
      logic xu;
      int pos[5] = '{4, 16, 20, 8, 25};
      if (cor) w[pos[$urandom % 5]] ^= 1'b1;
      xu = !cor && (!e || sz != 2'b00 || (q && (vd[0] || vm[0])));
      if ($urandom % 4 == 0) rf[{mh, vm}] = ($urandom % 2) ? '1 : '0;
      run(w, s, e, 1, {dh, vd}, {mh, vm}, q, xu, cor, "R1");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule